// File: doc/BRIEF.md
# Tuner PLL Synthesizer Control Core

This block is the digital core of a television-tuner frequency synthesizer. A host programs it over a three-wire serial port (serial clock, serial data, enable). Each word carries four band-select bits, a two-bit test field and a programmable divider ratio. A reference divider runs on the crystal-rate system clock. A programmable divider counts prescaled VCO edges, which arrive as single-cycle `fin_tick` strobes. A phase comparator turns the timing of the two divider pulses into source and sink requests for an external charge pump. A lock detector drives a status pin, and the test field can route either divider output onto that pin instead.

The reference ratio comes from a mode pin and from the length of the last accepted word. When the mode pin is low the ratio is 640. When the mode pin is high, a 19-bit word selects 1024 and an 18-bit word selects 512. Both dividers restart together whenever a new word is accepted, so a matched ratio starts in phase.

Top module: `tpll_ctrl`

## Requirements
- R1: Bits shift in MSB first on each falling edge of `ser_clk` while `ser_en` is high. Edges of `ser_clk` while `ser_en` is low are ignored and leave the bit count at zero.
- R2: When `ser_en` falls after exactly 18 bits, the word is accepted in the short format: band = first 4 bits, test = next 2 bits, divider ratio = last 12 bits.
- R3: The 19th falling edge accepts the word at once in the long format (band 4 bits, test 2 bits, ratio 13 bits). Any further clocks before `ser_en` falls are ignored.
- R4: A word with fewer than 18 bits when `ser_en` falls is discarded, and all settings keep their values.
- R5: With `mode_sel` low, the reference divider pulses once every 640 system clocks.
- R6: With `mode_sel` high, the reference divider pulses every 1024 clocks after a long word and every 512 clocks after a short word.
- R7: The programmable divider pulses once every N `fin_tick` strobes (N below 2 acts as 2). Both dividers restart on each accepted word.
- R8: `cp_src` is high from a divider pulse until the matching reference pulse (divider leads). `cp_snk` is high from a reference pulse until the matching divider pulse (divider lags). Pulses in the same cycle give neither, and the two outputs are never high together.
- R9: Lock is declared after 4 consecutive reference periods with no pump activity. Any cycle with `cp_src` or `cp_snk` high clears lock in the next cycle.
- R10: Test field 2'b01 drives the programmable divider pulse onto `ld_out`. Test field 2'b10 drives the reference pulse. 2'b00 and 2'b11 drive the lock status.
- R11: `band_out[3]` carries the first bit shifted in and `band_out[0]` the fourth; each output is 1 (on) when its bit is 1.
- R12: After reset, `band_out` is 0, both pump outputs are low, lock is clear, the test field selects lock status and the divider ratio is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate system clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial programming clock |
| ser_data | input | 1 | Serial programming data |
| ser_en | input | 1 | Serial enable, high while a word is sent |
| mode_sel | input | 1 | Reference ratio mode pin |
| fin_tick | input | 1 | One-cycle strobe per prescaled VCO edge |
| band_out | output | 4 | Band-select controls |
| cp_src | output | 1 | Charge-pump source request |
| cp_snk | output | 1 | Charge-pump sink request |
| ld_out | output | 1 | Lock status or selected test pulse |

## Verification
A wrong bit count or a wrong field split in the serial loader shows on `band_out` one cycle after the word is accepted. A bad divider ratio is harder to see directly, so the test field brings either divider onto `ld_out`, and pulses are counted over a fixed window of about five reference periods. A phase comparator that gets lead and lag backwards drives the wrong pump output within one reference period. A faulty lock counter either holds `ld_out` low after four quiet periods or leaves it high while the pump is active.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

    localparam int BAND_W    = 4;
    localparam int TEST_W    = 2;
    localparam int NDIV_W    = 13;
    localparam int SHORT_LEN = 18;
    localparam int LONG_LEN  = 19;
    localparam int CNT_W     = $clog2(LONG_LEN + 1);
    localparam int REF_W     = 11;
    localparam int REF_LOW   = 640;
    localparam int REF_LONG  = 1024;
    localparam int REF_SHORT = 512;
    localparam int DEF_NDIV  = 512;
    localparam int LOCK_N    = 4;

    typedef enum logic [TEST_W-1:0] {
        TM_LOCK  = 2'b00,
        TM_DIV   = 2'b01,
        TM_REF   = 2'b10,
        TM_LOCKB = 2'b11
    } test_e;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        test_e             test;
        logic [NDIV_W-1:0] ratio;
        logic              long_word;
    } settings_t;

    localparam settings_t SET_RESET = '{
        band: '0, test: TM_LOCK, ratio: NDIV_W'(DEF_NDIV), long_word: 1'b0};

    function automatic settings_t unpack_word(input logic [LONG_LEN-1:0] sr,
                                              input logic is_long);
        settings_t s;
        if (is_long) begin
            s.band  = sr[18:15];
            s.test  = test_e'(sr[14:13]);
            s.ratio = sr[12:0];
        end else begin
            s.band  = sr[17:14];
            s.test  = test_e'(sr[13:12]);
            s.ratio = {1'b0, sr[11:0]};
        end
        s.long_word = is_long;
        return s;
    endfunction

    function automatic logic [REF_W-1:0] ref_ratio(input logic mode, input logic is_long);
        if (!mode)   return REF_W'(REF_LOW);
        if (is_long) return REF_W'(REF_LONG);
        return REF_W'(REF_SHORT);
    endfunction

endpackage

// File: rtl/tpll_serial_if.sv
module tpll_serial_if
    import tpll_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_clk,
    input  logic      ser_data,
    input  logic      ser_en,
    output settings_t settings,
    output logic      load
);
    logic                sclk_q, en_q, done;
    logic [CNT_W-1:0]    bit_cnt;
    logic [LONG_LEN-1:0] sr;
    logic [LONG_LEN-1:0] sr_next;
    logic                sclk_fall, en_fall;

    assign sclk_fall = sclk_q & ~ser_clk;
    assign en_fall   = en_q & ~ser_en;
    assign sr_next   = {sr[LONG_LEN-2:0], ser_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            en_q     <= 1'b0;
            done     <= 1'b0;
            bit_cnt  <= '0;
            sr       <= '0;
            settings <= SET_RESET;
            load     <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
            en_q   <= ser_en;
            load   <= 1'b0;
            if (!ser_en) begin
                bit_cnt <= '0;
                done    <= 1'b0;
                if (en_fall && !done && bit_cnt == CNT_W'(SHORT_LEN)) begin
                    settings <= unpack_word(sr, 1'b0);
                    load     <= 1'b1;
                end
            end else if (sclk_fall && !done) begin
                sr      <= sr_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(LONG_LEN - 1)) begin
                    settings <= unpack_word(sr_next, 1'b1);
                    load     <= 1'b1;
                    done     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tpll_divider.sv
module tpll_divider #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    assign eff   = (ratio < W'(2)) ? W'(2) : ratio;
    assign pulse = tick && (cnt >= eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= pulse ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/tpll_phase_lock.sv
module tpll_phase_lock
    import tpll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic ref_p,
    input  logic div_p,
    output logic src,
    output logic snk,
    output logic locked
);
    localparam int LW = $clog2(LOCK_N + 1);
    logic          up_n, dn_n;
    logic [LW-1:0] good;

    assign up_n   = src | div_p;
    assign dn_n   = snk | ref_p;
    assign locked = (good == LW'(LOCK_N));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            src <= 1'b0;
            snk <= 1'b0;
        end else if (up_n && dn_n) begin
            src <= 1'b0;
            snk <= 1'b0;
        end else begin
            src <= up_n;
            snk <= dn_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            good <= '0;
        else if (src || snk)
            good <= '0;
        else if (ref_p && !locked)
            good <= good + 1'b1;
    end
endmodule

// File: rtl/tpll_ctrl.sv
module tpll_ctrl
    import tpll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    input  logic              mode_sel,
    input  logic              fin_tick,
    output logic [BAND_W-1:0] band_out,
    output logic              cp_src,
    output logic              cp_snk,
    output logic              ld_out
);
    settings_t cfg;
    logic      load, ref_p, div_p, locked;

    tpll_serial_if u_ser (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .settings(cfg), .load(load)
    );

    tpll_divider #(.W(REF_W)) u_refdiv (
        .clk(clk), .rst(rst), .restart(load), .tick(1'b1),
        .ratio(ref_ratio(mode_sel, cfg.long_word)), .pulse(ref_p)
    );

    tpll_divider #(.W(NDIV_W)) u_progdiv (
        .clk(clk), .rst(rst), .restart(load), .tick(fin_tick),
        .ratio(cfg.ratio), .pulse(div_p)
    );

    tpll_phase_lock u_pfd (
        .clk(clk), .rst(rst), .restart(load), .ref_p(ref_p), .div_p(div_p),
        .src(cp_src), .snk(cp_snk), .locked(locked)
    );

    assign band_out = cfg.band;

    always_comb begin
        case (cfg.test)
            TM_DIV:  ld_out = div_p;
            TM_REF:  ld_out = ref_p;
            default: ld_out = locked;
        endcase
    end
endmodule

// File: rtl/tpll_ctrl_chk.sv
module tpll_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] band_out,
    input logic       cp_src,
    input logic       cp_snk,
    input logic       locked,
    input logic       load
);
    AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cp_src && cp_snk)); // R8

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        (cp_src || cp_snk) |=> !locked); // R9

    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (!cp_src && !cp_snk)); // R9

    AST_BAND_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_out) |-> load); // R4

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load |=> !load); // R3
endmodule

bind tpll_ctrl tpll_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .band_out(band_out), .cp_src(cp_src),
    .cp_snk(cp_snk), .locked(locked), .load(load)
);

// File: tb/tpll_ctrl_test.sv
module tpll_ctrl_test;
    logic       clk = 1'b0, rst = 1'b1;
    logic       s_clk = 1'b0, s_data = 1'b0, s_en = 1'b0, mode = 1'b1, fin = 1'b0;
    logic [3:0] band;
    logic       src, snk, ld;

    tpll_ctrl uut (
        .clk(clk), .rst(rst), .ser_clk(s_clk), .ser_data(s_data), .ser_en(s_en),
        .mode_sel(mode), .fin_tick(fin), .band_out(band), .cp_src(src),
        .cp_snk(snk), .ld_out(ld)
    );

    always #10 clk = ~clk;

    typedef enum int {K_BAND, K_LDCNT, K_LDLVL, K_SRC, K_SNK} kind_e;
    typedef struct {
        kind_e kind;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0, n_fail = 0;
    int    ld_hi = 0, src_n = 0, snk_n = 0;
    logic  win_clr = 1'b0;

    always @(negedge clk) begin
        if (win_clr) begin
            ld_hi = 0; src_n = 0; snk_n = 0;
        end else begin
            if (ld)  ld_hi++;
            if (src) src_n++;
            if (snk) snk_n++;
        end
    end

    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it = q.pop_front();
                case (it.kind)
                    K_BAND:  act = int'(band);
                    K_LDCNT: act = ld_hi;
                    K_LDLVL: act = int'(ld);
                    K_SRC:   act = (src_n > 0) ? 1 : 0;
                    default: act = (snk_n > 0) ? 1 : 0;
                endcase
                n_chk++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input kind_e k, input int e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic flush();
        ->chk_ev;
        @(posedge clk);
    endtask

    task automatic send(input logic [20:0] w, input int n);
        @(negedge clk) s_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            s_data = w[i]; s_clk = 1'b1;
            repeat (2) @(negedge clk);
            s_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        s_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic window(input int cycles);
        @(posedge clk) win_clr = 1'b1;
        @(posedge clk) win_clr = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    function automatic logic [20:0] w18(input logic [3:0] b, input logic [1:0] t,
                                        input int n);
        return {3'b000, b, t, n[11:0]};
    endfunction

    function automatic logic [20:0] w19(input logic [3:0] b, input logic [1:0] t,
                                        input int n);
        return {2'b00, b, t, n[12:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_item(K_BAND, 0, "R12 band after reset");
        expect_item(K_LDLVL, 0, "R12 ld after reset");
        flush();
        n_chk++;
        if (src !== 1'b0 || snk !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 pump after reset actual=%b%b expected=00", src, snk);
        end
        fin = 1'b1;

        // R1: clock edges with enable low must not count
        s_data = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) s_clk = 1'b1;
            @(negedge clk) s_clk = 1'b0;
        end
        // R2 / R11 / R8 aligned / R9 lock
        send(w18(4'b1010, 2'b00, 512), 18);
        window(2600);
        expect_item(K_BAND, 4'b1010, "R1 R2 R11 short word band");
        expect_item(K_SRC, 0, "R8 aligned no source");
        expect_item(K_SNK, 0, "R8 aligned no sink");
        expect_item(K_LDLVL, 1, "R9 locked after quiet periods");
        flush();

        // R8 divider leads -> source, R9 lock lost
        send(w18(4'b1010, 2'b00, 500), 18);
        window(2600);
        expect_item(K_SRC, 1, "R8 lead gives source");
        expect_item(K_SNK, 0, "R8 lead no sink");
        expect_item(K_LDLVL, 0, "R9 unlocked when leading");
        flush();

        // R8 divider lags -> sink
        send(w18(4'b1010, 2'b00, 520), 18);
        window(2600);
        expect_item(K_SNK, 1, "R8 lag gives sink");
        expect_item(K_SRC, 0, "R8 lag no source");
        flush();

        // R4 short word discarded
        send({11'd0, 10'b0101111111}, 10);
        expect_item(K_BAND, 4'b1010, "R4 short word ignored");
        flush();

        // R6 short word, mode high: ref 512 -> 5 pulses
        send(w18(4'b0110, 2'b10, 256), 18);
        window(2600);
        expect_item(K_BAND, 4'b0110, "R11 band pattern");
        expect_item(K_LDCNT, 5, "R6 R10 ref 512 pulses");
        flush();

        // R3 / R6 long word, mode high: ref 1024 -> 2 pulses
        send(w19(4'b1001, 2'b10, 256), 19);
        window(2600);
        expect_item(K_BAND, 4'b1001, "R3 long word band");
        expect_item(K_LDCNT, 2, "R6 ref 1024 pulses");
        flush();

        // R3 extra clocks ignored, R7 / R10 divider routed: N=256 -> 10 pulses
        send({w19(4'b0011, 2'b01, 256), 2'b11}, 21);
        window(2600);
        expect_item(K_BAND, 4'b0011, "R3 extra bits ignored");
        expect_item(K_LDCNT, 10, "R7 R10 divider pulses");
        flush();

        // R5 mode low: ref 640 -> 4 pulses
        mode = 1'b0;
        send(w19(4'b1111, 2'b10, 256), 19);
        window(2600);
        expect_item(K_LDCNT, 4, "R5 ref 640 pulses");
        flush();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule